// File: doc/BRIEF.md
# Multi-Context Interrupt Controller

This block gathers a set of external interrupt sources and distributes them to several target contexts, where a context is one privilege mode on one hardware thread. Every source carries a programmable priority; every context keeps its own mask of enabled sources and its own priority threshold. Each context gets a single interrupt line. That line is raised whenever some source is pending, is enabled for that context, and has a priority above the context's threshold.

Software services an interrupt in two steps. It reads the context's claim word, which returns the best eligible source ID and atomically takes that source out of the pending set. It then writes the same ID back to the claim word to finish. While a source is being serviced, the source cannot become pending again. Each source is fixed at build time as edge-sensitive or level-sensitive. All state is reached through a single word-addressed register port with one operation per cycle.

Top module: `ctx_irq_ctrl`

## Requirements
- R1: The priority of source s (1..NUM_SRC) is written and read at address s. Only the low PRIO_W bits are kept. Address 0 and addresses above NUM_SRC read as 0, and writes to them are ignored.
- R2: Address 0x40 reads the pending set, with bit s standing for source s and bit 0 always 0. Writes to this address change nothing.
- R3: Address 0x80+c holds the enable mask of context c, with bit s enabling source s. A source that is not enabled for a context never raises that context's line and is never returned by that context's claim.
- R4: Address 0xC0+2c holds the threshold of context c. The context's line is high exactly when some pending source that is enabled for c has a priority strictly greater than that threshold. A source with priority 0 therefore never raises a line.
- R5: A read of address 0xC1+2c returns the eligible source with the highest priority, with ties going to the lowest ID. It returns 0 when no source is eligible.
- R6: A claim read that returns a nonzero ID clears that source's pending bit and marks the source in service at the same clock edge. No pending is latched for an in-service source, so edges that arrive during service are dropped.
- R7: For an edge source (bit s of EDGE_MASK set), a rising input sets pending. Pending then stays set after the input falls, until the source is claimed.
- R8: A level source becomes pending whenever its input is high. After completion, a level source whose input is still high becomes pending again one cycle later.
- R9: Writing ID d to address 0xC1+2c ends service of d only if d is in service and is enabled for context c. Any other such write is ignored.
- R10: After reset, all priorities, enables, thresholds, pending bits and in-service marks are 0, and every line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIn | input | NUM_SRC | Source inputs; bit k is source ID k+1 |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (required for a claim to take effect) |
| regAddr | input | 8 | Word address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Combinational read data for regAddr |
| irqOut | output | NUM_CTX | One interrupt line per context |

## Verification
Several properties are checked on every cycle by assertions. A source is never both pending and in service. A raised line always has a pending, enabled source behind it. A nonzero claim leaves its source in service and no longer pending. An accepted completion takes the source out of service. At most one kind of register write is decoded at a time. The selection order only shows up in the bench scenarios, which are compared against a behavioural model. That order covers priority ties, threshold edges, and priority-0 sources. The same scenarios show that edges are dropped during service, that level sources re-pend after completion, and that completion writes from the wrong context are ignored.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int ADDR_W = 8;
  localparam int OFF_W  = 6;

  typedef enum logic [2:0] {
    RD_NONE, RD_PRIO, RD_PEND, RD_EN, RD_THR, RD_CLAIM
  } rdSel_e;

  typedef struct packed {
    logic             prioWe;
    logic             enWe;
    logic             thrWe;
    logic             claimRe;
    logic             completeWe;
    rdSel_e           rdSel;
    logic [OFF_W-1:0] idx;
  } ctrlStrobes_t;
endpackage

// File: rtl/irqc_control.sv
module irqc_control
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 10,
  parameter int NUM_CTX = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrobes_t      strb
);
  logic [1:0]       grp;
  logic [OFF_W-1:0] off;
  logic [OFF_W-1:0] ctxOff;

  assign grp    = regAddr[ADDR_W-1:ADDR_W-2];
  assign off    = regAddr[OFF_W-1:0];
  assign ctxOff = {1'b0, off[OFF_W-1:1]};

  always_comb begin
    strb       = '0;
    strb.rdSel = RD_NONE;
    case (grp)
      2'd0: if (off != '0 && off <= OFF_W'(NUM_SRC)) begin
        strb.prioWe = regWe;
        strb.rdSel  = RD_PRIO;
        strb.idx    = off;
      end
      2'd1: if (off == '0) strb.rdSel = RD_PEND;
      2'd2: if (off < OFF_W'(NUM_CTX)) begin
        strb.enWe  = regWe;
        strb.rdSel = RD_EN;
        strb.idx   = off;
      end
      default: if (ctxOff < OFF_W'(NUM_CTX)) begin
        strb.idx = ctxOff;
        if (off[0]) begin
          strb.claimRe    = regRe;
          strb.completeWe = regWe;
          strb.rdSel      = RD_CLAIM;
        end else begin
          strb.thrWe = regWe;
          strb.rdSel = RD_THR;
        end
      end
    endcase
  end

  // R1 / R9: a single write selects at most one register kind
  p_one_write_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.prioWe, strb.enWe, strb.thrWe, strb.completeWe}));
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 10,
  parameter int NUM_CTX = 3,
  parameter int PRIO_W  = 3,
  parameter int DATA_W  = 32,
  parameter logic [NUM_SRC:0] EDGE_MASK = 'h0F0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  ctrlStrobes_t       strb,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  output logic [NUM_CTX-1:0] irqOut
);
  localparam int ID_W  = $clog2(NUM_SRC + 1);
  localparam int CTX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;
  localparam logic [NUM_SRC:0] EDGE_BITS = EDGE_MASK & ~(NUM_SRC+1)'(1);

  logic [PRIO_W-1:0]  prio      [NUM_SRC+1];
  logic [NUM_SRC:0]   enable    [NUM_CTX];
  logic [PRIO_W-1:0]  thr       [NUM_CTX];
  logic [NUM_SRC:0]   pending, inService, prevIn;
  logic [NUM_SRC:0]   srcVec, setReq, claimOH, doneOH, pendNext, svcNext;
  logic [NUM_CTX-1:0][ID_W-1:0] bestId;
  logic [ID_W-1:0]    srcIdx, claimId, doneId;
  logic [CTX_W-1:0]   ctxIdx;
  logic               doneOk;

  // per-context winner search: strictly greater keeps the lowest ID on ties,
  // and starting at the threshold filters sources at or below it
  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    logic [ID_W-1:0]   winId;
    logic [PRIO_W-1:0] winPrio;
    always_comb begin
      winId   = '0;
      winPrio = thr[c];
      for (int k = 1; k <= NUM_SRC; k++) begin
        if (pending[k] && enable[c][k] && prio[k] > winPrio) begin
          winId   = ID_W'(k);
          winPrio = prio[k];
        end
      end
    end
    assign bestId[c] = winId;
    assign irqOut[c] = (winId != '0);

    p_line_src_r4: assert property (@(posedge clk) disable iff (!rstN)
      irqOut[c] |-> ((pending & enable[c]) != '0));
  end

  assign srcIdx  = strb.idx[ID_W-1:0];
  assign ctxIdx  = strb.idx[CTX_W-1:0];
  assign claimId = bestId[ctxIdx];
  assign doneId  = regWdata[ID_W-1:0];
  assign doneOk  = strb.completeWe && (regWdata <= DATA_W'(NUM_SRC)) &&
                   (doneId != '0) && inService[doneId] && enable[ctxIdx][doneId];

  always_comb begin
    srcVec   = {srcIn, 1'b0};
    setReq   = (srcVec & ~prevIn & EDGE_BITS) | (srcVec & ~EDGE_BITS);
    claimOH  = (strb.claimRe && claimId != '0) ? ((NUM_SRC+1)'(1) << claimId) : '0;
    doneOH   = doneOk ? ((NUM_SRC+1)'(1) << doneId) : '0;
    pendNext = (pending | (setReq & ~inService)) & ~claimOH;
    svcNext  = (inService | claimOH) & ~doneOH;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k <= NUM_SRC; k++) prio[k] <= '0;
      for (int c = 0; c < NUM_CTX; c++) begin
        enable[c] <= '0;
        thr[c]    <= '0;
      end
      pending   <= '0;
      inService <= '0;
      prevIn    <= '0;
    end else begin
      prevIn    <= srcVec;
      pending   <= pendNext;
      inService <= svcNext;
      if (strb.prioWe) prio[srcIdx]   <= regWdata[PRIO_W-1:0];
      if (strb.enWe)   enable[ctxIdx] <= {regWdata[NUM_SRC:1], 1'b0};
      if (strb.thrWe)  thr[ctxIdx]    <= regWdata[PRIO_W-1:0];
    end
  end

  always_comb begin
    regRdata = '0;
    case (strb.rdSel)
      RD_PRIO:  regRdata[PRIO_W-1:0]  = prio[srcIdx];
      RD_PEND:  regRdata[NUM_SRC:0]   = pending;
      RD_EN:    regRdata[NUM_SRC:0]   = enable[ctxIdx];
      RD_THR:   regRdata[PRIO_W-1:0]  = thr[ctxIdx];
      RD_CLAIM: regRdata[ID_W-1:0]    = claimId;
      default:  regRdata = '0;
    endcase
  end

  // R6: no source is pending and in service at once
  p_exclusive_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pending & inService) == '0);
  // R6: a nonzero claim moves the source into service
  p_claim_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.claimRe && claimId != '0) |=>
      (inService[$past(claimId)] && !pending[$past(claimId)]));
  // R9: an accepted completion ends service
  p_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneOk |=> !inService[$past(doneId)]);
endmodule

// File: rtl/ctx_irq_ctrl.sv
module ctx_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 10,
  parameter int NUM_CTX = 3,
  parameter int PRIO_W  = 3,
  parameter logic [NUM_SRC:0] EDGE_MASK = 'h0F0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               regWe,
  input  logic               regRe,
  input  logic [7:0]         regAddr,
  input  logic [31:0]        regWdata,
  output logic [31:0]        regRdata,
  output logic [NUM_CTX-1:0] irqOut
);
  ctrlStrobes_t strb;

  irqc_control #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX)) u_control (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe),
    .regAddr(regAddr), .strb(strb)
  );

  irqc_datapath #(
    .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .PRIO_W(PRIO_W),
    .DATA_W(32), .EDGE_MASK(EDGE_MASK)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .strb(strb),
    .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut)
  );
endmodule

// File: tb/ctx_irq_ctrl_bench.sv
module ctx_irq_ctrl_bench;
  localparam int NS = 10;
  localparam int NC = 3;
  localparam int PW = 3;
  localparam logic [NS:0] EDGES = 'h0F0;   // sources 4..7 edge, rest level

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] srcIn = '0;
  logic          regWe = 1'b0, regRe = 1'b0;
  logic [7:0]    regAddr = '0;
  logic [31:0]   regWdata = '0;
  logic [31:0]   regRdata;
  logic [NC-1:0] irqOut;

  int total = 0, failed = 0;
  bit running = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  ctx_irq_ctrl #(.NUM_SRC(NS), .NUM_CTX(NC), .PRIO_W(PW), .EDGE_MASK(EDGES)) u_ctx_irq_ctrl (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .regWe(regWe), .regRe(regRe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut)
  );

  // ---------------- behavioural reference model ----------------
  int mPrio [NS+1];
  bit mEn   [NC][NS+1];
  int mThr  [NC];
  bit mPend [NS+1];
  bit mSvc  [NS+1];
  bit mPrev [NS+1];

  function automatic int mBest(int c);
    int res = 0;
    for (int p = (1 << PW) - 1; p > mThr[c]; p--)
      for (int id = 1; id <= NS; id++)
        if (res == 0 && mPend[id] && mEn[c][id] && mPrio[id] == p) res = id;
    return res;
  endfunction

  function automatic int mRead(int a);
    int g = a / 64, o = a % 64, v = 0;
    if (g == 0) v = (o >= 1 && o <= NS) ? mPrio[o] : 0;
    else if (g == 1) begin
      if (o == 0) for (int id = 1; id <= NS; id++) if (mPend[id]) v += (1 << id);
    end else if (g == 2) begin
      if (o < NC) for (int id = 1; id <= NS; id++) if (mEn[o][id]) v += (1 << id);
    end else if (o / 2 < NC) v = (o % 2 == 1) ? mBest(o / 2) : mThr[o / 2];
    return v;
  endfunction

  task automatic modelStep();
    int g = int'(regAddr) / 64, o = int'(regAddr) % 64, c = o / 2;
    int claimed = 0, done = 0;
    if (g == 3 && c < NC && o % 2 == 1) begin
      if (regRe) claimed = mBest(c);
      if (regWe && regWdata >= 1 && regWdata <= NS) begin
        if (mSvc[int'(regWdata)] && mEn[c][int'(regWdata)]) done = int'(regWdata);
      end
    end
    for (int id = 1; id <= NS; id++) begin
      bit inp = srcIn[id-1];
      bit setIt = EDGES[id] ? (inp && !mPrev[id]) : inp;
      if (setIt && !mSvc[id]) mPend[id] = 1'b1;
      mPrev[id] = inp;
    end
    if (claimed != 0) begin mPend[claimed] = 1'b0; mSvc[claimed] = 1'b1; end
    if (done != 0) mSvc[done] = 1'b0;
    if (regWe) begin
      if (g == 0 && o >= 1 && o <= NS) mPrio[o] = int'(regWdata) % (1 << PW);
      if (g == 2 && o < NC) for (int id = 1; id <= NS; id++) mEn[o][id] = regWdata[id];
      if (g == 3 && c < NC && o % 2 == 0) mThr[c] = int'(regWdata) % (1 << PW);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      for (int id = 0; id <= NS; id++) begin
        mPrio[id] = 0; mPend[id] = 0; mSvc[id] = 0; mPrev[id] = 0;
        for (int c = 0; c < NC; c++) mEn[c][id] = 0;
      end
      for (int c = 0; c < NC; c++) mThr[c] = 0;
    end else modelStep();
  end

  // ---------------- checking ----------------
  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      for (int c = 0; c < NC; c++) begin
        if (!rstN) check(irqOut[c] == 1'b0, "R10 line low in reset", int'(irqOut[c]), 0);
        else check(irqOut[c] == (mBest(c) != 0), "R4 line vs model",
                   int'(irqOut[c]), int'(mBest(c) != 0));
      end
    end
  end

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(int a, int d);
    regAddr = 8'(a); regWdata = 32'(d); regWe = 1'b1;
    @(posedge clk); #1;
    regWe = 1'b0;
  endtask

  task automatic rd(int a, int exp, string tag);
    int got, mdl;
    regAddr = 8'(a); regRe = 1'b1;
    #4;
    got = int'(regRdata);
    mdl = mRead(a);
    check(got == mdl, tag, got, mdl);
    if (exp >= 0) check(got == exp, tag, got, exp);
    @(posedge clk); #1;
    regRe = 1'b0;
  endtask

  task automatic setSrc(int id, bit v);
    srcIn[id-1] = v;
  endtask

  initial begin
    #(8 * 100000);
    check(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    running = 1'b1;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    rd(8'hC1, 0, "R10 claim after reset");
    rd(8'h40, 0, "R10 pending after reset");
    rd(8'h03, 0, "R10 priority after reset");

    // priorities and masks
    wr(1, 1); wr(2, 2); wr(3, 2); wr(4, 3); wr(5, 5);
    wr(6, 5); wr(7, 7); wr(8, 1); wr(9, 0); wr(10, 4);
    wr(8'h80, 32'h7FE); wr(8'h81, 32'h24); wr(8'h82, 0);
    rd(5, 5, "R1 priority readback");
    rd(8'h81, 32'h24, "R3 enable readback");
    rd(8'h82, 0, "R3 enable readback ctx2");

    // level source 3
    setSrc(3, 1); idle(1);
    rd(8'h40, 8, "R8 level sets pending");
    rd(8'hC3, 0, "R3 disabled source not claimable");
    rd(8'hC1, 3, "R5 claim returns level source");
    rd(8'h40, 0, "R6 claimed source not re-pended");
    wr(8'hC3, 3); idle(1);
    rd(8'h40, 0, "R9 completion from wrong context ignored");
    wr(8'hC1, 9); idle(1);
    rd(8'h40, 0, "R9 completion of idle ID ignored");
    wr(8'hC1, 3); idle(1);
    rd(8'h40, 8, "R8 level re-pends after completion");
    rd(8'hC1, 3, "R5 reclaim level source");
    setSrc(3, 0); wr(8'hC1, 3); idle(1);
    rd(8'h40, 0, "R8 low level stays clear");

    // edge source 5
    setSrc(5, 1); idle(1); setSrc(5, 0); idle(1);
    rd(8'h40, 32'h20, "R7 edge latched after fall");
    check(irqOut[2] == 1'b0, "R3 masked context line", int'(irqOut[2]), 0);
    check(irqOut[1] == 1'b1, "R3 enabled context line", int'(irqOut[1]), 1);
    rd(8'hC3, 5, "R5 ctx1 claims edge source");
    setSrc(5, 1); idle(1); setSrc(5, 0); idle(1);
    rd(8'h40, 0, "R6 edge during service dropped");
    wr(8'hC3, 5);
    setSrc(5, 1); setSrc(6, 1); idle(1); setSrc(5, 0); setSrc(6, 0); idle(1);
    rd(8'h40, 32'h60, "R7 two edges latched");
    rd(8'hC1, 5, "R5 tie goes to lowest ID");
    rd(8'hC1, 6, "R5 next in tie");
    wr(8'hC1, 5); wr(8'hC1, 6);

    // thresholds
    setSrc(7, 1); setSrc(4, 1); idle(1); setSrc(7, 0); setSrc(4, 0); idle(1);
    rd(8'h40, 32'h90, "R7 pending for sources 4 and 7");
    wr(8'hC0, 7); idle(1);
    check(irqOut[0] == 1'b0, "R4 threshold equal blocks line", int'(irqOut[0]), 0);
    rd(8'hC1, 0, "R4 claim blocked at threshold");
    wr(8'hC0, 6);
    rd(8'hC0, 6, "R4 threshold readback");
    rd(8'hC1, 7, "R5 highest priority wins");
    wr(8'hC0, 3);
    rd(8'hC1, 0, "R4 priority equal to threshold blocked");
    wr(8'hC0, 2);
    rd(8'hC1, 4, "R4 priority above threshold claimed");
    wr(8'hC1, 7); wr(8'hC1, 4); wr(8'hC0, 0);

    // priority 0 source
    setSrc(9, 1); idle(1);
    rd(8'h40, 32'h200, "R8 level pending for priority 0 source");
    check(irqOut[0] == 1'b0, "R4 priority 0 never interrupts", int'(irqOut[0]), 0);
    rd(8'hC1, 0, "R4 priority 0 never claimed");
    setSrc(9, 0);

    // register corner cases
    wr(0, 5); rd(0, 0, "R1 address 0 ignored");
    wr(11, 5); rd(11, 0, "R1 address above sources ignored");
    wr(1, 32'hFF); rd(1, 7, "R1 priority masked to width");
    wr(8'h40, 32'hFFFF); rd(8'h40, 32'h200, "R2 pending not writable");

    idle(2);
    running = 1'b0;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule